// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block is the control core of a contact smart card interface. It rests in an idle mode with every card contact switched off and waits for the host to ask for a session. A session request is honoured only if the host I/O line is not being held low, the main supply is good, the host supply alarm is clear and no hardware fault is flagged. The sequencer then switches the card supply on, enables the programming supply and the I/O path together after a fixed delay, and finally releases the card clock and reset after a second, longer delay. Once all contacts are up, the block reports read or write mode according to a host direction input.

When the host withdraws its request, or when the supply, the alarm or a hardware fault demands it, the contacts are taken down in the reverse order, one step per fixed interval. A loss of supply or a raised alarm returns the block to idle. A hardware fault instead parks it in a fault mode, which is left only once the request has been withdrawn and the fault has cleared. A free-running divided reference clock and two status lines report to the host at all times. All pins are plain level signals sampled on the system clock. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `scard_sequencer`

## Requirements
- R1: After reset, mode reads 0 (idle), all five contact enables are low and no_fault is high.
- R2: Idle moves to activation (mode 1) one clock after a cycle in which all of these hold: sess_req_n is low, host_io is high, supply_ok is high, alarm is low and hw_fault is low. If any of them fails, the block stays in idle.
- R3: vcc_en rises first, on the edge that enters activation. vpp_en and io_en rise together exactly T1 cycles later, where T1 = CLK_HZ / 1e6 * 16 (160 at the default 10 MHz).
- R4: clk_en and rst_en rise together exactly T2 cycles after vpp_en, where T2 = CLK_HZ / 1e6 * 64 (640 at default). On that same edge the mode becomes read (2) if dir_write is low, or write (3) if it is high.
- R5: While a session is active, the mode follows dir_write one clock later: 2 for read, 3 for write.
- R6: Raising sess_req_n during activation, read or write enters deactivation (mode 4) on the next edge, and rst_en falls on that edge. clk_en falls DEACT_STEP_CYC cycles later. vpp_en and io_en fall together one more DEACT_STEP_CYC later. vcc_en falls after a further DEACT_STEP_CYC, on the same edge that mode returns to 0.
- R7: supply_ok low or alarm high during activation, read or write forces deactivation on the next edge. If no hardware fault has been seen, the block ends in idle (mode 0).
- R8: hw_fault high during activation, read, write or deactivation makes deactivation end in fault mode (5) with all contacts low. Fault mode is kept until a cycle in which sess_req_n is high and hw_fault is low.
- R9: card_detect equals card_present. no_fault is low whenever hw_fault is high or the mode is fault, and high otherwise.
- R10: ref_clk toggles on every clock edge after reset, in every mode (at the default REF_DIV_LOG2 of 1).
- R11: No contact enable ever rises while the block is in deactivation. An abort in the middle of activation only turns off the contacts that are already on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_req_n | input | 1 | Host session request, active low |
| host_io | input | 1 | Level of the host I/O line |
| card_present | input | 1 | Card presence flag |
| supply_ok | input | 1 | Main supply above its threshold |
| alarm | input | 1 | Host supply alarm, high when bad |
| hw_fault | input | 1 | Hardware fault flag |
| dir_write | input | 1 | Session direction: 1 write, 0 read |
| vcc_en | output | 1 | Card supply enable |
| vpp_en | output | 1 | Programming supply enable |
| io_en | output | 1 | Card I/O path enable (off means high impedance) |
| clk_en | output | 1 | Card clock enable |
| rst_en | output | 1 | Card reset line enable |
| card_detect | output | 1 | Presence status |
| no_fault | output | 1 | High while no hardware problem is present |
| mode | output | 3 | 0 idle, 1 activation, 2 read, 3 write, 4 deactivation, 5 fault |
| ref_clk | output | 1 | Divided free-running reference clock |

## Verification
The bench measures the exact cycle gaps between contact steps in both directions. A timer that is off by one, or that is not restarted when a step changes, shows up as a gap of 159 or 641 cycles instead of 160 or 640. Each activation gating condition is tried alone, so a design that ignores the host I/O level or the alarm would start a session it should refuse. An alarm raised halfway through activation must never let the clock contact rise, which catches a teardown that is decoded from step number alone. The fault exit is tested with only one of its two conditions met at a time, which catches a design that leaves fault mode as soon as the flag drops.

// File: rtl/scard_pkg.sv
package scard_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_ACT   = 3'd1,
    M_READ  = 3'd2,
    M_WRITE = 3'd3,
    M_DEACT = 3'd4,
    M_FAULT = 3'd5
  } mode_e;

  // contact vector bit positions
  localparam int C_VCC  = 0;
  localparam int C_VPP  = 1;
  localparam int C_IO   = 2;
  localparam int C_CLK  = 3;
  localparam int C_RST  = 4;
  localparam int NCONT  = 5;

  // timer limit selection
  localparam logic [1:0] G_VCC_VPP = 2'd0;
  localparam logic [1:0] G_VPP_CLK = 2'd1;
  localparam logic [1:0] G_DEACT   = 2'd2;

endpackage

// File: rtl/scard_gap_timer.sv
module scard_gap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/scard_ref_div.sv
module scard_ref_div #(
  parameter int DIV_LOG2 = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_clk
);

  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign ref_clk = div_q[DIV_LOG2-1];

endmodule

// File: rtl/scard_seq_fsm.sv
module scard_seq_fsm
  import scard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sess_req_n,
  input  logic             host_io,
  input  logic             supply_ok,
  input  logic             alarm,
  input  logic             hw_fault,
  input  logic             dir_write,
  input  logic             timer_done,
  output logic             timer_restart,
  output logic [1:0]       gap_sel,
  output mode_e            mode,
  output logic [NCONT-1:0] contacts
);

  mode_e            state_q, state_d;
  logic [1:0]       step_q, step_d;
  logic             faulted_q, faulted_d;
  logic [NCONT-1:0] cont_q, cont_d;
  logic             supply_bad, abort, may_start;
  mode_e            dir_mode;

  assign supply_bad = !supply_ok || alarm;
  assign abort      = supply_bad || hw_fault || sess_req_n;
  assign may_start  = !sess_req_n && host_io && !supply_bad && !hw_fault;
  assign dir_mode   = dir_write ? M_WRITE : M_READ;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    faulted_d = faulted_q;
    cont_d    = cont_q;
    unique case (state_q)
      M_IDLE: begin
        if (may_start) begin
          state_d       = M_ACT;
          step_d        = 2'd0;
          cont_d[C_VCC] = 1'b1;
        end
      end
      M_ACT: begin
        if (abort) begin
          state_d       = M_DEACT;
          step_d        = 2'd0;
          cont_d[C_RST] = 1'b0;
          faulted_d     = hw_fault;
        end else if (timer_done) begin
          if (step_q == 2'd0) begin
            step_d        = 2'd1;
            cont_d[C_VPP] = 1'b1;
            cont_d[C_IO]  = 1'b1;
          end else begin
            state_d       = dir_mode;
            step_d        = 2'd0;
            cont_d[C_CLK] = 1'b1;
            cont_d[C_RST] = 1'b1;
          end
        end
      end
      M_READ, M_WRITE: begin
        if (abort) begin
          state_d       = M_DEACT;
          step_d        = 2'd0;
          cont_d[C_RST] = 1'b0;
          faulted_d     = hw_fault;
        end else begin
          state_d = dir_mode;
        end
      end
      M_DEACT: begin
        if (hw_fault) faulted_d = 1'b1;
        if (timer_done) begin
          unique case (step_q)
            2'd0: begin
              step_d        = 2'd1;
              cont_d[C_CLK] = 1'b0;
            end
            2'd1: begin
              step_d        = 2'd2;
              cont_d[C_VPP] = 1'b0;
              cont_d[C_IO]  = 1'b0;
            end
            default: begin
              step_d        = 2'd0;
              cont_d[C_VCC] = 1'b0;
              state_d       = faulted_d ? M_FAULT : M_IDLE;
            end
          endcase
        end
      end
      M_FAULT: begin
        if (sess_req_n && !hw_fault) begin
          state_d   = M_IDLE;
          faulted_d = 1'b0;
        end
      end
      default: begin
        state_d   = M_IDLE;
        step_d    = 2'd0;
        faulted_d = 1'b0;
        cont_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= M_IDLE;
      step_q    <= 2'd0;
      faulted_q <= 1'b0;
      cont_q    <= '0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      faulted_q <= faulted_d;
      cont_q    <= cont_d;
    end
  end

  assign timer_restart = (state_d != state_q) || (step_d != step_q);
  assign gap_sel = (state_q == M_ACT) ? ((step_q == 2'd0) ? G_VCC_VPP : G_VPP_CLK)
                                      : G_DEACT;
  assign mode     = state_q;
  assign contacts = cont_q;

endmodule

// File: rtl/scard_sequencer.sv
module scard_sequencer
  import scard_pkg::*;
#(
  parameter int CLK_HZ         = 10_000_000,
  parameter int VCC_VPP_US     = 16,
  parameter int VPP_CLK_US     = 64,
  parameter int DEACT_STEP_CYC = 20,
  parameter int REF_DIV_LOG2   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sess_req_n,
  input  logic       host_io,
  input  logic       card_present,
  input  logic       supply_ok,
  input  logic       alarm,
  input  logic       hw_fault,
  input  logic       dir_write,
  output logic       vcc_en,
  output logic       vpp_en,
  output logic       io_en,
  output logic       clk_en,
  output logic       rst_en,
  output logic       card_detect,
  output logic       no_fault,
  output logic [2:0] mode,
  output logic       ref_clk
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int T1_RAW     = CYC_PER_US * VCC_VPP_US;
  localparam int T2_RAW     = CYC_PER_US * VPP_CLK_US;
  localparam int T1         = (T1_RAW < 1) ? 1 : T1_RAW;
  localparam int T2         = (T2_RAW < 1) ? 1 : T2_RAW;
  localparam int TD         = (DEACT_STEP_CYC < 1) ? 1 : DEACT_STEP_CYC;
  localparam int TMAX_A     = (T1 > T2) ? T1 : T2;
  localparam int TMAX       = (TMAX_A > TD) ? TMAX_A : TD;
  localparam int CW         = $clog2(TMAX + 1);

  logic             timer_restart, timer_done;
  logic [1:0]       gap_sel;
  logic [CW-1:0]    limit;
  mode_e            mode_int;
  logic [NCONT-1:0] contacts;

  always_comb begin
    unique case (gap_sel)
      G_VCC_VPP: limit = CW'(T1);
      G_VPP_CLK: limit = CW'(T2);
      default:   limit = CW'(TD);
    endcase
  end

  scard_gap_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .limit   (limit),
    .done    (timer_done)
  );

  scard_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sess_req_n    (sess_req_n),
    .host_io       (host_io),
    .supply_ok     (supply_ok),
    .alarm         (alarm),
    .hw_fault      (hw_fault),
    .dir_write     (dir_write),
    .timer_done    (timer_done),
    .timer_restart (timer_restart),
    .gap_sel       (gap_sel),
    .mode          (mode_int),
    .contacts      (contacts)
  );

  scard_ref_div #(.DIV_LOG2(REF_DIV_LOG2)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_clk (ref_clk)
  );

  assign vcc_en      = contacts[C_VCC];
  assign vpp_en      = contacts[C_VPP];
  assign io_en       = contacts[C_IO];
  assign clk_en      = contacts[C_CLK];
  assign rst_en      = contacts[C_RST];
  assign mode        = mode_int;
  assign card_detect = card_present;
  assign no_fault    = !hw_fault && (mode_int != M_FAULT);

endmodule

// File: rtl/scard_sequencer_chk.sv
module scard_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sess_req_n,
  input logic       hw_fault,
  input logic [2:0] mode,
  input logic       vcc_en,
  input logic       vpp_en,
  input logic       io_en,
  input logic       clk_en,
  input logic       rst_en,
  input logic       no_fault,
  input logic       ref_clk
);

  logic [4:0] cv;
  assign cv = {rst_en, clk_en, io_en, vpp_en, vcc_en};

  // R1: idle and fault keep every contact off
  a_r1_idle_contacts_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd0) || (mode == 3'd5)) |-> (cv == 5'd0));

  // R3: programming supply and I/O path move as a pair, only under VCC
  a_r3_vpp_io_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en == io_en) && (!vpp_en || vcc_en));

  // R4: clock and reset only with the I/O path up
  a_r4_clk_rst_need_io: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en || rst_en) |-> io_en);

  // R11: nothing switches on while tearing down
  a_r11_no_rise_in_deact: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> ((cv & ~$past(cv)) == 5'd0));

  // R8: fault mode held while the request is still asserted
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd5) && !sess_req_n) |=> (mode == 3'd5));

  // R9: no_fault drops with a raised fault flag
  a_r9_no_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fault |-> !no_fault);

  // R10: reference clock toggles every edge
  a_r10_ref_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_clk != $past(ref_clk)));

endmodule

bind scard_sequencer scard_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sess_req_n (sess_req_n),
  .hw_fault   (hw_fault),
  .mode       (mode),
  .vcc_en     (vcc_en),
  .vpp_en     (vpp_en),
  .io_en      (io_en),
  .clk_en     (clk_en),
  .rst_en     (rst_en),
  .no_fault   (no_fault),
  .ref_clk    (ref_clk)
);

// File: tb/tb_scard_sequencer.sv
module tb_scard_sequencer;

  localparam int T1 = 10 * 16;   // 10 MHz x 16 us
  localparam int T2 = 10 * 64;   // 10 MHz x 64 us
  localparam int TD = 20;

  // {sess_req_n, host_io, supply_ok, alarm, hw_fault, expect_start}
  localparam logic [5:0] VEC [0:5] = '{
    6'b011001,   // all conditions met
    6'b111000,   // no request
    6'b001000,   // host I/O held low
    6'b010000,   // supply not good
    6'b011100,   // alarm raised
    6'b011010    // hardware fault
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess_req_n = 1'b1, host_io = 1'b1, card_present = 1'b0;
  logic supply_ok = 1'b1, alarm = 1'b0, hw_fault = 1'b0, dir_write = 1'b0;
  logic vcc_en, vpp_en, io_en, clk_en, rst_en, card_detect, no_fault, ref_clk;
  logic [2:0] mode;
  logic [4:0] cv;
  int checks = 0;
  int failures = 0;

  assign cv = {rst_en, clk_en, io_en, vpp_en, vcc_en};

  always #5 clk = ~clk;

  scard_sequencer dut (
    .clk(clk), .rst_n(rst_n), .sess_req_n(sess_req_n), .host_io(host_io),
    .card_present(card_present), .supply_ok(supply_ok), .alarm(alarm),
    .hw_fault(hw_fault), .dir_write(dir_write), .vcc_en(vcc_en),
    .vpp_en(vpp_en), .io_en(io_en), .clk_en(clk_en), .rst_en(rst_en),
    .card_detect(card_detect), .no_fault(no_fault), .mode(mode),
    .ref_clk(ref_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_bit(input int idx, input logic val, output int n);
    n = 0;
    while (cv[idx] != val && n < 5000) begin
      tick();
      n++;
    end
  endtask

  task automatic wait_mode(input logic [2:0] m);
    for (int i = 0; i < 3000 && mode != m; i++) tick();
  endtask

  task automatic go_active();
    sess_req_n = 1'b0;
    for (int i = 0; i < 3000 && mode != 3'd2 && mode != 3'd3; i++) tick();
  endtask

  task automatic safe_idle();
    sess_req_n = 1'b1; supply_ok = 1'b1; alarm = 1'b0; hw_fault = 1'b0;
    host_io = 1'b1; dir_write = 1'b0;
    wait_mode(3'd0);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int rises;
    logic prev;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 contacts", cv, 0);
    chk("R1 no_fault", no_fault, 1);

    // R2 gating table
    for (int v = 0; v < 6; v++) begin
      sess_req_n = VEC[v][5]; host_io = VEC[v][4]; supply_ok = VEC[v][3];
      alarm = VEC[v][2]; hw_fault = VEC[v][1];
      tick(); tick();
      chk($sformatf("R2 vec%0d mode", v), mode, VEC[v][0] ? 1 : 0);
      chk($sformatf("R2 vec%0d vcc", v), vcc_en, VEC[v][0] ? 1 : 0);
      safe_idle();
    end

    // R3 / R4 activation timing, read direction
    sess_req_n = 1'b0;
    tick();
    chk("R3 vcc first", cv, 5'b00001);
    chk("R3 mode act", mode, 1);
    wait_bit(1, 1'b1, n);
    chk("R3 vcc->vpp gap", n, T1);
    chk("R3 io with vpp", io_en, 1);
    chk("R3 clk not yet", clk_en, 0);
    wait_bit(3, 1'b1, n);
    chk("R4 vpp->clk gap", n, T2);
    chk("R4 rst with clk", rst_en, 1);
    chk("R4 mode read", mode, 2);

    // R5 direction following
    dir_write = 1'b1; tick();
    chk("R5 write mode", mode, 3);
    dir_write = 1'b0; tick();
    chk("R5 read mode", mode, 2);

    // R10 reference clock toggling in a session
    prev = ref_clk;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R10 ref toggle", ref_clk, !prev);
      prev = ref_clk;
    end

    // R6 orderly teardown
    sess_req_n = 1'b1; tick();
    chk("R6 deact mode", mode, 4);
    chk("R6 rst off first", cv, 5'b01111);
    wait_bit(3, 1'b0, n);
    chk("R6 clk gap", n, TD);
    chk("R6 vpp still on", vpp_en, 1);
    wait_bit(1, 1'b0, n);
    chk("R6 vpp gap", n, TD);
    chk("R6 io with vpp", io_en, 0);
    chk("R6 vcc still on", vcc_en, 1);
    wait_bit(0, 1'b0, n);
    chk("R6 vcc gap", n, TD);
    chk("R6 back to idle", mode, 0);

    // R10 reference clock in idle
    prev = ref_clk;
    tick();
    chk("R10 ref toggle idle", ref_clk, !prev);

    // R7 supply loss while reading
    go_active();
    chk("R7 active before loss", mode, 2);
    supply_ok = 1'b0; tick();
    chk("R7 deact on supply loss", mode, 4);
    wait_mode(3'd0);
    chk("R7 ends idle", mode, 0);
    chk("R7 contacts off", cv, 0);
    safe_idle();

    // R11 / R7 alarm in the middle of activation
    sess_req_n = 1'b0;
    wait_bit(1, 1'b1, n);
    alarm = 1'b1; tick();
    chk("R11 deact on alarm", mode, 4);
    rises = 0;
    for (int i = 0; i < 200 && mode != 3'd0; i++) begin
      if (clk_en || rst_en) rises++;
      tick();
    end
    chk("R11 clk/rst never on", rises, 0);
    chk("R7 alarm ends idle", mode, 0);
    safe_idle();

    // R8 / R9 hardware fault while writing
    dir_write = 1'b1;
    go_active();
    chk("R5 write on activation", mode, 3);
    hw_fault = 1'b1; tick();
    chk("R8 deact on fault", mode, 4);
    chk("R9 no_fault low", no_fault, 0);
    for (int i = 0; i < 200 && mode == 3'd4; i++) tick();
    chk("R8 fault mode", mode, 5);
    chk("R8 contacts off", cv, 0);
    sess_req_n = 1'b1; repeat (3) tick();
    chk("R8 held while flag high", mode, 5);
    sess_req_n = 1'b0; hw_fault = 1'b0; repeat (3) tick();
    chk("R8 held while requested", mode, 5);
    chk("R9 no_fault low in fault", no_fault, 0);
    sess_req_n = 1'b1; tick();
    chk("R8 fault exit", mode, 0);
    chk("R9 no_fault restored", no_fault, 1);
    safe_idle();

    // R9 presence status
    card_present = 1'b1; tick();
    chk("R9 detect high", card_detect, 1);
    card_present = 1'b0; tick();
    chk("R9 detect low", card_detect, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule